// File: doc/BRIEF.md
# Reset-Time Configuration Strap Capture

This block reads a group of configuration strap pins once per reset, when the board-level active-low reset is released. It keeps the captured values constant until the next reset and decodes them into configuration flags. The flags cover the role of the media-independent interface (MAC or PHY), the source of the boot code and of the memory setup, and the defaults for PHY role: link speed, duplex, start-up isolation and the management address. The same reset also drives an active-low reset for an external Ethernet PHY. That reset is released a fixed number of clocks after the board reset. A clock-enable output lets the 25 MHz PHY clock run only when the captured role is MAC.

The raw reset clears the block asynchronously. Its release is taken through a synchronizer. The strap pins pass through a two-stage synchronizer of their own. The capture happens on the first clock edge after the synchronized release. From that point every output is a pure decode of the held straps.

Top module: `cfg_strap_capture`

## Requirements
- R1: While `rst_n_raw` is low, `cfg_valid`, `phy_rst_n`, `phy_clk_en` and every decode output are 0. This takes effect without waiting for a clock edge.
- R2: `cfg_valid` goes to 1 after the third rising clock edge that follows the release of `rst_n_raw`. The held straps are the values present at the first rising edge after the release.
- R3: Once `cfg_valid` is 1, changes on the strap inputs do not affect any output until the next assertion of `rst_n_raw`.
- R4: `role_mac` is 1 when `strap_role` was 1 (MAC role) and 0 when it was 0 (PHY role).
- R5: The boot decode maps {`strap_boot_sel`,`strap_cfg_sel`} as follows. 00 gives `boot_mem_flash`=0 and `boot_code_flash`=0 (both from the host). 01 gives memory setup from flash and code from the host. 11 gives both from flash.
- R6: The combination {`strap_boot_sel`,`strap_cfg_sel`} = 10 sets `boot_unsupported`=1 with both flash flags 0. Every other combination gives `boot_unsupported`=0.
- R7: `phy_speed_100` equals `strap_speed` (1 = 100 Mb/s, 0 = 10 Mb/s). `phy_full_duplex` equals `strap_duplex` (1 = full, 0 = half).
- R8: `phy_isolate` is 1 only when `strap_iso` was 1 and the role is PHY. In MAC role it is 0.
- R9: `phy_mgmt_addr` is `strap_addr` times 8, giving 0x00, 0x08, 0x10 or 0x18.
- R10: `phy_rst_n` goes high after rising edge 2+`PHY_RST_HOLD` (default 16) following the release of `rst_n_raw`. It is never high before `cfg_valid`.
- R11: `phy_clk_en` is 1 exactly when `cfg_valid` is 1 and the role is MAC.
- R12: A new reset pulse clears the held state. That includes a pulse that arrives while `phy_rst_n` is still being held low. The straps are then captured again with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n_raw | input | 1 | Board reset, active low, asynchronous |
| strap_role | input | 1 | Role strap: 1 MAC, 0 PHY |
| strap_boot_sel | input | 1 | Boot code source strap |
| strap_cfg_sel | input | 1 | Memory setup source strap |
| strap_speed | input | 1 | PHY-role speed strap |
| strap_duplex | input | 1 | PHY-role duplex strap |
| strap_iso | input | 1 | PHY-role start-isolated strap |
| strap_addr | input | 2 | Management address straps |
| cfg_valid | output | 1 | Straps captured and held |
| role_mac | output | 1 | Interface acts as MAC |
| boot_mem_flash | output | 1 | Memory setup loaded from flash |
| boot_code_flash | output | 1 | Boot code loaded from flash |
| boot_unsupported | output | 1 | Unsupported boot combination captured |
| phy_speed_100 | output | 1 | 100 Mb/s default |
| phy_full_duplex | output | 1 | Full duplex default |
| phy_isolate | output | 1 | Start isolated (PHY role only) |
| phy_mgmt_addr | output | 5 | Management address |
| phy_rst_n | output | 1 | Stretched reset to external PHY, active low |
| phy_clk_en | output | 1 | Enable for the PHY clock output |

## Verification
The first round of resets walks all eight combinations of role and the two boot straps. Each one also carries varied speed, duplex, isolate and address bits, which separates the boot matrix (the unsupported code included) and the role-gated isolate and clock enable. A further set of resets uses scattered full-width patterns, including all zeros and all ones. These catch swapped or stuck strap bits. After each capture the strap inputs are inverted, which shows whether anything leaks past the hold. A reset pulse placed in the middle of the PHY reset stretch checks the asynchronous clear and the fresh capture that follows it.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  localparam int ADDR_STRAP_W = 2;
  localparam int ADDR_SHIFT   = 3;
  localparam int MGMT_ADDR_W  = ADDR_STRAP_W + ADDR_SHIFT;

  typedef struct packed {
    logic                    role;
    logic                    boot_sel;
    logic                    cfg_sel;
    logic                    speed;
    logic                    duplex;
    logic                    iso;
    logic [ADDR_STRAP_W-1:0] addr;
  } strap_t;

  localparam int STRAP_W = $bits(strap_t);

  typedef struct packed {
    logic mem_flash;
    logic code_flash;
    logic bad;
  } boot_t;

  function automatic boot_t boot_decode(input logic boot_sel, input logic cfg_sel);
    boot_t r;
    r.bad        = boot_sel & ~cfg_sel;
    r.code_flash = boot_sel & cfg_sel;
    r.mem_flash  = cfg_sel;
    return r;
  endfunction

  function automatic logic [MGMT_ADDR_W-1:0] mgmt_addr_of(input logic [ADDR_STRAP_W-1:0] a);
    return {a, {ADDR_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic stretched_n
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == LAST) rel_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stretched_n = rel_q;
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_cfg_pkg::*;
(
  input  strap_t                 held,
  input  logic                   valid,
  output logic                   role_mac,
  output logic                   mem_flash,
  output logic                   code_flash,
  output logic                   unsupported,
  output logic                   speed_100,
  output logic                   full_duplex,
  output logic                   isolate,
  output logic [MGMT_ADDR_W-1:0] mgmt_addr,
  output logic                   clk_en
);
  boot_t boot;

  always_comb begin
    boot        = boot_decode(held.boot_sel, held.cfg_sel);
    role_mac    = valid & held.role;
    mem_flash   = valid & boot.mem_flash;
    code_flash  = valid & boot.code_flash;
    unsupported = valid & boot.bad;
    speed_100   = valid & held.speed;
    full_duplex = valid & held.duplex;
    isolate     = valid & held.iso & ~held.role;
    mgmt_addr   = valid ? mgmt_addr_of(held.addr) : '0;
    clk_en      = valid & held.role;
  end
endmodule

// File: rtl/cfg_strap_capture.sv
module cfg_strap_capture
  import strap_cfg_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PHY_RST_HOLD = 16
) (
  input  logic                   clk,
  input  logic                   rst_n_raw,
  input  logic                   strap_role,
  input  logic                   strap_boot_sel,
  input  logic                   strap_cfg_sel,
  input  logic                   strap_speed,
  input  logic                   strap_duplex,
  input  logic                   strap_iso,
  input  logic [ADDR_STRAP_W-1:0] strap_addr,
  output logic                   cfg_valid,
  output logic                   role_mac,
  output logic                   boot_mem_flash,
  output logic                   boot_code_flash,
  output logic                   boot_unsupported,
  output logic                   phy_speed_100,
  output logic                   phy_full_duplex,
  output logic                   phy_isolate,
  output logic [MGMT_ADDR_W-1:0] phy_mgmt_addr,
  output logic                   phy_rst_n,
  output logic                   phy_clk_en
);
  strap_t raw_straps;
  strap_t synced;
  strap_t held_q;
  logic   valid_q;
  logic   sys_rst_n;
  logic   latch_evt;

  assign raw_straps = '{role: strap_role, boot_sel: strap_boot_sel, cfg_sel: strap_cfg_sel,
                        speed: strap_speed, duplex: strap_duplex, iso: strap_iso,
                        addr: strap_addr};

  strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_straps),
    .q   (synced)
  );

  rst_release_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n_raw),
    .srst_n (sys_rst_n)
  );

  // capture pulse: first enabled edge after the synchronized release
  assign latch_evt = sys_rst_n & ~valid_q;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      held_q  <= '0;
      valid_q <= 1'b0;
    end else if (latch_evt) begin
      held_q  <= synced;
      valid_q <= 1'b1;
    end
  end

  assign cfg_valid = valid_q;

  strap_decode u_dec (
    .held        (held_q),
    .valid       (valid_q),
    .role_mac    (role_mac),
    .mem_flash   (boot_mem_flash),
    .code_flash  (boot_code_flash),
    .unsupported (boot_unsupported),
    .speed_100   (phy_speed_100),
    .full_duplex (phy_full_duplex),
    .isolate     (phy_isolate),
    .mgmt_addr   (phy_mgmt_addr),
    .clk_en      (phy_clk_en)
  );

  rst_stretch #(.HOLD_CYCLES(PHY_RST_HOLD)) u_stretch (
    .clk         (clk),
    .rst_n       (sys_rst_n),
    .stretched_n (phy_rst_n)
  );
endmodule

// File: rtl/cfg_strap_capture_chk.sv
module cfg_strap_capture_chk
  import strap_cfg_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n_raw,
  input logic                   sys_rst_n,
  input logic                   latch_evt,
  input logic                   cfg_valid,
  input logic                   role_mac,
  input logic                   boot_mem_flash,
  input logic                   boot_code_flash,
  input logic                   boot_unsupported,
  input logic                   phy_speed_100,
  input logic                   phy_full_duplex,
  input logic                   phy_isolate,
  input logic [MGMT_ADDR_W-1:0] phy_mgmt_addr,
  input logic                   phy_rst_n,
  input logic                   phy_clk_en
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_raw |-> (!cfg_valid && !phy_rst_n && !phy_clk_en && !role_mac));

  // R2
  single_capture_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    latch_evt |=> (cfg_valid && !latch_evt));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (cfg_valid && $past(cfg_valid)) |->
      $stable({role_mac, boot_mem_flash, boot_code_flash, boot_unsupported,
               phy_speed_100, phy_full_duplex, phy_isolate, phy_mgmt_addr}));

  // R6
  boot_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    boot_unsupported |-> (cfg_valid && !boot_mem_flash && !boot_code_flash));

  // R8
  iso_role_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    phy_isolate |-> !role_mac);

  // R9
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    phy_mgmt_addr[ADDR_SHIFT-1:0] == '0);

  // R10
  phy_rst_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    phy_rst_n |-> cfg_valid);

  // R11
  clk_en_role_chk: assert property (@(posedge clk) disable iff (!rst_n_raw)
    phy_clk_en |-> (role_mac && cfg_valid));
endmodule

bind cfg_strap_capture cfg_strap_capture_chk u_chk (
  .clk              (clk),
  .rst_n_raw        (rst_n_raw),
  .sys_rst_n        (sys_rst_n),
  .latch_evt        (latch_evt),
  .cfg_valid        (cfg_valid),
  .role_mac         (role_mac),
  .boot_mem_flash   (boot_mem_flash),
  .boot_code_flash  (boot_code_flash),
  .boot_unsupported (boot_unsupported),
  .phy_speed_100    (phy_speed_100),
  .phy_full_duplex  (phy_full_duplex),
  .phy_isolate      (phy_isolate),
  .phy_mgmt_addr    (phy_mgmt_addr),
  .phy_rst_n        (phy_rst_n),
  .phy_clk_en       (phy_clk_en)
);

// File: tb/sim_cfg_strap_capture.sv
module sim_cfg_strap_capture;
  localparam int STG  = 2;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n_raw;
  logic [7:0] sv;   // {role, boot_sel, cfg_sel, speed, duplex, iso, addr[1:0]}

  logic       cfg_valid, role_mac, boot_mem_flash, boot_code_flash, boot_unsupported;
  logic       phy_speed_100, phy_full_duplex, phy_isolate, phy_rst_n, phy_clk_en;
  logic [4:0] phy_mgmt_addr;

  cfg_strap_capture #(.SYNC_STAGES(STG), .PHY_RST_HOLD(HOLD)) u0 (
    .clk              (clk),
    .rst_n_raw        (rst_n_raw),
    .strap_role       (sv[7]),
    .strap_boot_sel   (sv[6]),
    .strap_cfg_sel    (sv[5]),
    .strap_speed      (sv[4]),
    .strap_duplex     (sv[3]),
    .strap_iso        (sv[2]),
    .strap_addr       (sv[1:0]),
    .cfg_valid        (cfg_valid),
    .role_mac         (role_mac),
    .boot_mem_flash   (boot_mem_flash),
    .boot_code_flash  (boot_code_flash),
    .boot_unsupported (boot_unsupported),
    .phy_speed_100    (phy_speed_100),
    .phy_full_duplex  (phy_full_duplex),
    .phy_isolate      (phy_isolate),
    .phy_mgmt_addr    (phy_mgmt_addr),
    .phy_rst_n        (phy_rst_n),
    .phy_clk_en       (phy_clk_en)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model: edges since release and a short history of strap samples
  int         since = 0;
  logic [7:0] hist[$];
  logic [7:0] cap = '0;
  bit         mdl_valid = 0;

  always @(posedge clk) begin
    if (!rst_n_raw) begin
      since = 0;
      hist.delete();
      mdl_valid = 0;
    end else begin
      since++;
      hist.push_back(sv);
      if (hist.size() > STG + 1) void'(hist.pop_front());
      if (since == STG + 1) begin
        cap = hist[0];
        mdl_valid = 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit ev;
      int e_mem, e_code, e_bad, e_role, e_rst;
      ev     = rst_n_raw && mdl_valid;
      e_role = ev ? int'(cap[7]) : 0;
      e_mem = 0; e_code = 0; e_bad = 0;
      if (ev) begin
        case (cap[6:5])
          2'b00: begin e_mem = 0; e_code = 0; end
          2'b01: begin e_mem = 1; e_code = 0; end
          2'b10: e_bad = 1;
          default: begin e_mem = 1; e_code = 1; end
        endcase
      end
      e_rst = (rst_n_raw && since >= STG + HOLD) ? 1 : 0;
      chk(rst_n_raw ? "R2" : "R1", "cfg_valid", int'(cfg_valid), ev ? 1 : 0);
      chk("R4", "role_mac", int'(role_mac), e_role);
      chk("R5", "boot_mem_flash", int'(boot_mem_flash), e_mem);
      chk("R5", "boot_code_flash", int'(boot_code_flash), e_code);
      chk("R6", "boot_unsupported", int'(boot_unsupported), e_bad);
      chk("R7", "phy_speed_100", int'(phy_speed_100), ev ? int'(cap[4]) : 0);
      chk("R7", "phy_full_duplex", int'(phy_full_duplex), ev ? int'(cap[3]) : 0);
      chk("R8", "phy_isolate", int'(phy_isolate), (ev && cap[2] && !cap[7]) ? 1 : 0);
      chk("R9", "phy_mgmt_addr", int'(phy_mgmt_addr), ev ? int'(cap[1:0]) * 8 : 0);
      chk("R10", "phy_rst_n", int'(phy_rst_n), e_rst);
      chk("R11", "phy_clk_en", int'(phy_clk_en), e_role);
    end
  end

  task automatic boot_with(input logic [7:0] v, input int run_cycles);
    @(posedge clk); #1;
    rst_n_raw = 1'b0;
    sv = v;
    repeat (4) @(posedge clk);
    #1 rst_n_raw = 1'b1;
    repeat (run_cycles) @(posedge clk);
  endtask

  // R3: invert straps after capture; outputs must not move
  task automatic disturb(input logic [7:0] v);
    #1 sv = ~v;
    repeat (8) @(posedge clk);
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n_raw = 1'b0;
    sv = 8'h00;
    repeat (3) @(posedge clk);
    // R4 R5 R6 R7 R8 R9 R11: every role/boot combination
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = {3'(i), 5'((i * 11 + 3) & 31)};
      boot_with(v, STG + HOLD + 6);
      disturb(v);
    end
    // scattered full-width patterns
    for (int k = 0; k < 16; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 53 + 7) & 255);
      boot_with(v, STG + HOLD + 4);
      disturb(v);
    end
    // R12: reset pulse during the PHY reset stretch, then a new capture
    boot_with(8'h9D, 8);
    boot_with(8'h46, STG + HOLD + 6);
    disturb(8'h46);
    boot_with(8'hB3, STG + HOLD + 6);
    finish_up();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      finish_up();
    end
  end
endmodule